// File: doc/BRIEF.md
# Configuration Request Retry Handler

This block sits in a root port between the host's configuration access port and the link-side request and completion path. It takes one configuration read or write at a time from the host and sends it to the link. It then classifies the completion status that comes back. A completion that asks for a retry (status code 2) is not passed up to software. The block waits about one microsecond and sends the same request again. It keeps doing this until the device answers or a bounded retry window runs out.

There is one exception. If software has turned on retry visibility and the request is a read of dword 0 (the vendor identifier register), a retry status is not retried. The block answers at once with the fixed word 0xFFFF0001 and does not raise the retry indication. Read results are reduced to the access width: the 32-bit word is shifted right by eight times the low two address bits and masked to one or two bytes. The tick length and the window length are parameters derived from the clock frequency, so a simulation can use a short window.

Top module: `cfg_retry_handler`

## Requirements
- R1: After reset, `req_ready` is 1, and `lnk_req_valid`, `rsp_done`, `rsp_err` and `rsp_crs` are 0.
- R2: A read whose completion status is 0 (success) produces exactly one link request. It then produces a single-cycle `rsp_done` pulse carrying the completion data, with `rsp_err` = 0 and `rsp_crs` = 0.
- R3: When `cfg_sv_enable` is 0 (sampled when the request is accepted), each completion with status 2 makes the block send the request to the link again. The final successful completion supplies the result, so N retry completions give N+1 link requests. While `lnk_req_ready` is low, `lnk_req_valid`, `lnk_req_addr` and `lnk_req_write` hold steady.
- R4: When `cfg_sv_enable` is 1 and a read of dword 0 (address bits above bit 1 all zero) completes with status 2, the block issues no further request. The result is 0xFFFF0001, shaped per R9, with `rsp_crs` = 0 and `rsp_err` = 0.
- R5: When `cfg_sv_enable` is 1, writes and reads of any dword other than 0 that complete with status 2 are still sent again, as in R3.
- R6: A reissued request reaches the link no sooner than GAP cycles (RETRY_GAP_US microseconds) after the retry completion that caused it.
- R7: A read that still receives status 2 once WINDOW_US microseconds have passed since acceptance completes with data all ones (shaped per R9) and `rsp_crs` = 1, `rsp_err` = 0. The done pulse comes no earlier than the window length after acceptance.
- R8: A write that runs out of the window in the same way completes with `rsp_err` = 1, `rsp_crs` = 1 and `rsp_data` = 0.
- R9: `req_size` encodes the access width: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. For one- and two-byte reads, `rsp_data` is the 32-bit result shifted right by 8 × `req_addr[1:0]` and masked to the width, with missing upper bytes read as zero. A four-byte read returns the word unshifted.
- R10: A completion status other than 0 or 2 ends the request at once with no retry and `rsp_err` = 1. The data is all ones (shaped per R9) for reads and 0 for writes.
- R11: Only one request is outstanding: `req_ready` is 0 from the cycle after acceptance until the done pulse has been given.
- R12: A write passes `req_wdata` to `lnk_req_wdata` unchanged. A successful write completes with `rsp_data` = 0, `rsp_err` = 0 and `rsp_crs` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sv_enable | input | 1 | Retry visibility enable, sampled with each request |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Configuration register byte address |
| req_size | input | 2 | Access width code (0 byte, 1 halfword, 2/3 word) |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse to the host |
| rsp_data | output | 32 | Read result, valid with `rsp_done` |
| rsp_err | output | 1 | Error flag, valid with `rsp_done` |
| rsp_crs | output | 1 | Retry window expired, valid with `rsp_done` |
| lnk_req_valid | output | 1 | Link request valid |
| lnk_req_ready | input | 1 | Link request accepted |
| lnk_req_write | output | 1 | Link request is a write |
| lnk_req_addr | output | ADDR_W | Link request byte address |
| lnk_req_size | output | 2 | Link request width code |
| lnk_req_wdata | output | 32 | Link write data |
| lnk_cpl_valid | input | 1 | Completion valid |
| lnk_cpl_status | input | 3 | Completion status (0 success, 2 retry, others error) |
| lnk_cpl_data | input | 32 | Completion data |

## Verification
Random transactions draw a read or write, an address in the first sixteen dwords, a width, the visibility bit, a count of zero to three retry completions and sometimes an error status. A random scripted link stalls acceptance and varies the completion latency. Comparing the number of link requests with the number of retry replies separates hardware reissue from the synthesized vendor identifier answer. The same comparison shows that visibility only shortcuts dword 0 reads. Directed cases never stop answering with retry status, once for a read and once for a write, which separates the expiry path from ordinary retries and fixes when the done pulse may arrive. Byte and halfword reads at every offset tell the shift-and-mask path apart from a plain word return.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [2:0] CPL_OK  = 3'd0;
  localparam logic [2:0] CPL_CRS = 3'd2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [DATA_W-1:0] VIS_WORD = 32'hFFFF_0001;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_GAP   = 3'd3,
    ST_DONE  = 3'd4
  } cfgrt_state_e;

endpackage

// File: rtl/cfgrt_timer.sv
module cfgrt_timer #(
  parameter int TICK_CYCLES = 50,
  parameter int GAP_CYCLES  = 50,
  parameter int WINDOW_US   = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic gap_start_i,
  output logic gap_done_o,
  output logic expired_o
);

  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam int US_W  = $clog2(WINDOW_US + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [US_W-1:0]  us_q, us_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_busy_q, gap_busy_d;
  logic             tick;

  assign tick       = (pre_q == PRE_W'(TICK_CYCLES - 1));
  assign expired_o  = (us_q >= US_W'(WINDOW_US));
  assign gap_done_o = gap_busy_q && (gap_q == '0);

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (start_i) begin
      pre_d = '0;
      us_d  = '0;
    end else if (tick) begin
      pre_d = '0;
      if (!expired_o) us_d = us_q + US_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_comb begin
    gap_d      = gap_q;
    gap_busy_d = gap_busy_q;
    if (gap_start_i) begin
      gap_d      = GAP_W'(GAP_CYCLES - 1);
      gap_busy_d = 1'b1;
    end else if (gap_busy_q) begin
      if (gap_q == '0) gap_busy_d = 1'b0;
      else             gap_d      = gap_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      us_q       <= '0;
      gap_q      <= '0;
      gap_busy_q <= 1'b0;
    end else begin
      pre_q      <= pre_d;
      us_q       <= us_d;
      gap_q      <= gap_d;
      gap_busy_q <= gap_busy_d;
    end
  end

  // R7
  expiry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> (pre_q == '0))
    else $error("window expiry not aligned to a microsecond tick");

endmodule

// File: rtl/cfgrt_shaper.sv
module cfgrt_shaper
  import cfgrt_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] data_o
);

  logic [1:0] eff_off;
  logic [2:0] nbytes;

  always_comb begin
    case (size_i)
      SZ_BYTE: nbytes = 3'd1;
      SZ_HALF: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    eff_off = (nbytes == 3'd4) ? 2'd0 : off_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2:0] src;
    logic       lane_on;
    assign src     = {1'b0, eff_off} + 3'(g);
    assign lane_on = (src < 3'(LANES)) && (3'(g) < nbytes);
    always_comb begin
      if (lane_on) data_o[8*g +: 8] = word_i[8*src[1:0] +: 8];
      else         data_o[8*g +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/cfgrt_ctrl.sv
module cfgrt_ctrl
  import cfgrt_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int GAP_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sv_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              rsp_crs,
  output logic [DATA_W-1:0] res_word,
  output logic [1:0]        res_off,
  output logic [1:0]        res_size,
  output logic              lnk_req_valid,
  input  logic              lnk_req_ready,
  output logic              lnk_req_write,
  output logic [ADDR_W-1:0] lnk_req_addr,
  output logic [1:0]        lnk_req_size,
  output logic [DATA_W-1:0] lnk_req_wdata,
  input  logic              lnk_cpl_valid,
  input  logic [2:0]        lnk_cpl_status,
  input  logic [DATA_W-1:0] lnk_cpl_data,
  output logic              timer_start,
  output logic              gap_start,
  input  logic              gap_done,
  input  logic              window_expired
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  cfgrt_state_e      state_q, state_d;
  logic              capture;
  logic              wr_q, sv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] res_q, res_d;
  logic              err_q, err_d, crs_q, crs_d;
  logic              vid_hit;
  logic [GAP_W-1:0]  gap_seen_q;

  assign vid_hit       = (addr_q[ADDR_W-1:2] == '0);
  assign req_ready     = (state_q == ST_IDLE);
  assign lnk_req_valid = (state_q == ST_ISSUE);
  assign lnk_req_write = wr_q;
  assign lnk_req_addr  = addr_q;
  assign lnk_req_size  = size_q;
  assign lnk_req_wdata = wdata_q;
  assign rsp_done      = (state_q == ST_DONE);
  assign rsp_err       = err_q;
  assign rsp_crs       = crs_q;
  assign res_word      = res_q;
  assign res_off       = addr_q[1:0];
  assign res_size      = size_q;

  always_comb begin
    state_d     = state_q;
    capture     = 1'b0;
    timer_start = 1'b0;
    gap_start   = 1'b0;
    res_d       = res_q;
    err_d       = err_q;
    crs_d       = crs_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          capture     = 1'b1;
          timer_start = 1'b1;
          err_d       = 1'b0;
          crs_d       = 1'b0;
          res_d       = '0;
          state_d     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (lnk_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (lnk_cpl_valid) begin
          if (lnk_cpl_status == CPL_OK) begin
            res_d   = wr_q ? '0 : lnk_cpl_data;
            state_d = ST_DONE;
          end else if (lnk_cpl_status == CPL_CRS) begin
            if (!wr_q && sv_q && vid_hit) begin
              res_d   = VIS_WORD;
              state_d = ST_DONE;
            end else if (window_expired) begin
              res_d   = wr_q ? '0 : '1;
              err_d   = wr_q;
              crs_d   = 1'b1;
              state_d = ST_DONE;
            end else begin
              gap_start = 1'b1;
              state_d   = ST_GAP;
            end
          end else begin
            res_d   = wr_q ? '0 : '1;
            err_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_GAP: begin
        if (gap_done) state_d = ST_ISSUE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      err_q   <= 1'b0;
      crs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      err_q   <= err_d;
      crs_q   <= crs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      sv_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      wr_q    <= req_write;
      sv_q    <= cfg_sv_enable;
      addr_q  <= req_addr;
      size_q  <= req_size;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_seen_q <= '0;
    else if (state_q != ST_GAP)  gap_seen_q <= '0;
    else                         gap_seen_q <= gap_seen_q + GAP_W'(1);
  end

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready)
    else $error("second request accepted while busy");

  // R3
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req_valid && !lnk_req_ready) |=>
      (lnk_req_valid && $stable(lnk_req_addr) && $stable(lnk_req_write)))
    else $error("link request changed while stalled");

  // R7
  crs_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_crs) |-> window_expired)
    else $error("retry indication before window expiry");

  // R6
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && gap_done) |-> (gap_seen_q >= GAP_W'(GAP_CYCLES - 1)))
    else $error("reissue gap too short");

  // R10
  err_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && lnk_cpl_valid && lnk_cpl_status != CPL_OK &&
     lnk_cpl_status != CPL_CRS) |=> (rsp_done && rsp_err))
    else $error("error status not reported");

  // R4
  synth_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && lnk_cpl_valid && lnk_cpl_status == CPL_CRS &&
     !wr_q && sv_q && vid_hit) |=> (rsp_done && !rsp_crs && !rsp_err))
    else $error("visible retry not answered directly");

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done)
    else $error("done longer than one cycle");

endmodule

// File: rtl/cfg_retry_handler.sv
module cfg_retry_handler
  import cfgrt_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int CLK_FREQ_HZ  = 50_000_000,
  parameter int RETRY_GAP_US = 1,
  parameter int WINDOW_US    = 500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sv_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              rsp_crs,
  output logic              lnk_req_valid,
  input  logic              lnk_req_ready,
  output logic              lnk_req_write,
  output logic [ADDR_W-1:0] lnk_req_addr,
  output logic [1:0]        lnk_req_size,
  output logic [31:0]       lnk_req_wdata,
  input  logic              lnk_cpl_valid,
  input  logic [2:0]        lnk_cpl_status,
  input  logic [31:0]       lnk_cpl_data
);

  localparam int TICK_CYCLES = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int GAP_CYCLES  = TICK_CYCLES * RETRY_GAP_US;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              timer_start, gap_start, gap_done, window_expired;
  logic [DATA_W-1:0] res_word;
  logic [1:0]        res_off, res_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cfgrt_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .GAP_CYCLES (GAP_CYCLES),
    .WINDOW_US  (WINDOW_US)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (timer_start),
    .gap_start_i(gap_start),
    .gap_done_o (gap_done),
    .expired_o  (window_expired)
  );

  cfgrt_ctrl #(
    .ADDR_W    (ADDR_W),
    .GAP_CYCLES(GAP_CYCLES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .cfg_sv_enable (cfg_sv_enable),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .rsp_done      (rsp_done),
    .rsp_err       (rsp_err),
    .rsp_crs       (rsp_crs),
    .res_word      (res_word),
    .res_off       (res_off),
    .res_size      (res_size),
    .lnk_req_valid (lnk_req_valid),
    .lnk_req_ready (lnk_req_ready),
    .lnk_req_write (lnk_req_write),
    .lnk_req_addr  (lnk_req_addr),
    .lnk_req_size  (lnk_req_size),
    .lnk_req_wdata (lnk_req_wdata),
    .lnk_cpl_valid (lnk_cpl_valid),
    .lnk_cpl_status(lnk_cpl_status),
    .lnk_cpl_data  (lnk_cpl_data),
    .timer_start   (timer_start),
    .gap_start     (gap_start),
    .gap_done      (gap_done),
    .window_expired(window_expired)
  );

  cfgrt_shaper u_shaper (
    .word_i(res_word),
    .off_i (res_off),
    .size_i(res_size),
    .data_o(rsp_data)
  );

endmodule

// File: tb/cfg_retry_handler_tb_top.sv
`timescale 1ns/1ps
module cfg_retry_handler_tb_top;

  localparam int CLK_NS  = 20;
  localparam int WIN_US  = 20;
  localparam int GAP     = 50;
  localparam int WIN_CYC = WIN_US * 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sv_enable, req_valid, req_ready, req_write;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_done, rsp_err, rsp_crs;
  logic [31:0] rsp_data;
  logic        lnk_req_valid, lnk_req_ready, lnk_req_write;
  logic [11:0] lnk_req_addr;
  logic [1:0]  lnk_req_size;
  logic [31:0] lnk_req_wdata;
  logic        lnk_cpl_valid;
  logic [2:0]  lnk_cpl_status;
  logic [31:0] lnk_cpl_data;

  always #(CLK_NS/2) clk = ~clk;

  cfg_retry_handler #(.ADDR_W(12), .CLK_FREQ_HZ(50_000_000),
                      .RETRY_GAP_US(1), .WINDOW_US(WIN_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sv_enable(cfg_sv_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_crs(rsp_crs),
    .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
    .lnk_req_write(lnk_req_write), .lnk_req_addr(lnk_req_addr),
    .lnk_req_size(lnk_req_size), .lnk_req_wdata(lnk_req_wdata),
    .lnk_cpl_valid(lnk_cpl_valid), .lnk_cpl_status(lnk_cpl_status),
    .lnk_cpl_data(lnk_cpl_data));

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scripted link model
  logic [31:0] mem [0:15];
  int          crs_left, req_cnt, pend, last_crs_cyc, min_gap;
  logic [2:0]  fail_status;
  bit          fast_link;
  logic        rec_wr;
  logic [11:0] rec_addr;
  logic [31:0] rec_wdata;

  initial begin
    lnk_req_ready = 0; lnk_cpl_valid = 0; lnk_cpl_status = 0; lnk_cpl_data = 0;
    pend = 0; crs_left = 0; req_cnt = 0; last_crs_cyc = -1; min_gap = 1000000;
    fail_status = 0; fast_link = 0;
    forever begin
      @(negedge clk);
      lnk_cpl_valid = 0;
      lnk_req_ready = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          lnk_cpl_valid = 1;
          lnk_cpl_data  = $urandom;
          if (crs_left != 0) begin
            lnk_cpl_status = 3'd2;
            if (crs_left > 0) crs_left--;
            last_crs_cyc = cyc;
          end else if (fail_status != 0) begin
            lnk_cpl_status = fail_status;
          end else begin
            lnk_cpl_status = 3'd0;
            if (rec_wr) mem[rec_addr[5:2]] = rec_wdata;
            else        lnk_cpl_data = mem[rec_addr[5:2]];
          end
        end
      end else if (lnk_req_valid && (fast_link || ($urandom % 3 != 0))) begin
        lnk_req_ready = 1;
        req_cnt++;
        rec_wr = lnk_req_write; rec_addr = lnk_req_addr; rec_wdata = lnk_req_wdata;
        if (last_crs_cyc >= 0 && (cyc - last_crs_cyc) < min_gap) min_gap = cyc - last_crs_cyc;
        pend = fast_link ? 1 : 1 + ($urandom % 3);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] shape(input logic [31:0] w, input logic [1:0] off, input logic [1:0] sz);
    if (sz == 2'd0) return (w >> (8 * off)) & 32'hFF;
    if (sz == 2'd1) return (w >> (8 * off)) & 32'hFFFF;
    return w;
  endfunction

  logic [31:0] r_data;
  bit          r_err, r_crs, r_busy;
  int          r_cyc;

  task automatic run_txn(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit sv, input int crs, input logic [2:0] fst);
    int n;
    @(negedge clk);
    crs_left = crs; fail_status = fst; req_cnt = 0; last_crs_cyc = -1; min_gap = 1000000;
    req_valid = 1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    cfg_sv_enable = sv;
    r_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
    r_busy = req_ready;
    n = 0;
    while (!rsp_done && n < 4000) begin @(negedge clk); n++; end
    chk(n < 4000, "R11 done within bound", n, 4000);
    r_data = rsp_data; r_err = rsp_err; r_crs = rsp_crs;
    r_cyc = cyc - r_cyc;
    @(negedge clk);
    chk(!rsp_done, "R2 done is one cycle", rsp_done, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
    cfg_sv_enable = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1 && lnk_req_valid == 0 && rsp_done == 0 && rsp_err == 0 && rsp_crs == 0,
        "R1 reset state", {req_ready, lnk_req_valid, rsp_done, rsp_err, rsp_crs}, 32'h10);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 plain read
    exp = mem[3];
    run_txn(0, 12'h00C, 2'd2, 0, 0, 0, 0);
    chk(r_data == exp && !r_err && !r_crs, "R2 success read data", r_data, exp);
    chk(req_cnt == 1, "R2 single link request", req_cnt, 1);
    chk(r_busy == 0, "R11 ready low after accept", r_busy, 0);

    // R3 retries, visibility off, dword 0
    exp = mem[0];
    run_txn(0, 12'h000, 2'd2, 0, 0, 3, 0);
    chk(r_data == exp && !r_crs, "R3 data after retries", r_data, exp);
    chk(req_cnt == 4, "R3 reissue count", req_cnt, 4);
    chk(min_gap >= GAP, "R6 reissue spacing", min_gap, GAP);

    // R4 visibility on, vendor id read, byte and halfword
    run_txn(0, 12'h000, 2'd1, 0, 1, 2, 0);
    chk(r_data == 32'h0001 && !r_crs && !r_err, "R4 synthesized halfword", r_data, 32'h0001);
    chk(req_cnt == 1, "R4 no reissue", req_cnt, 1);
    run_txn(0, 12'h002, 2'd1, 0, 1, 1, 0);
    chk(r_data == 32'hFFFF, "R4 synthesized upper half", r_data, 32'hFFFF);
    run_txn(0, 12'h000, 2'd2, 0, 1, 1, 0);
    chk(r_data == 32'hFFFF0001, "R4 synthesized word", r_data, 32'hFFFF0001);

    // R5 visibility on, other dword retried
    exp = mem[1];
    run_txn(0, 12'h004, 2'd2, 0, 1, 2, 0);
    chk(r_data == exp && req_cnt == 3, "R5 non-vendor read retried", r_data, exp);
    run_txn(1, 12'h000, 2'd2, 32'hA5A5_5A5A, 1, 1, 0);
    chk(req_cnt == 2 && !r_err && r_data == 0, "R5 write to dword 0 retried", req_cnt, 2);
    chk(mem[0] == 32'hA5A5_5A5A && rec_wdata == 32'hA5A5_5A5A, "R12 write data passed", rec_wdata, 32'hA5A5_5A5A);

    // R9 byte lanes
    for (int o = 0; o < 4; o++) begin
      exp = shape(mem[5], 2'(o), 2'd0);
      run_txn(0, 12'h014 + 12'(o), 2'd0, 0, 0, 0, 0);
      chk(r_data == exp, "R9 byte extract", r_data, exp);
      exp = shape(mem[5], 2'(o), 2'd1);
      run_txn(0, 12'h014 + 12'(o), 2'd1, 0, 0, 0, 0);
      chk(r_data == exp, "R9 halfword extract", r_data, exp);
    end

    // R10 error status
    run_txn(0, 12'h008, 2'd0, 0, 0, 0, 3'd1);
    chk(r_data == 32'hFF && r_err && !r_crs && req_cnt == 1, "R10 error read", r_data, 32'hFF);
    run_txn(1, 12'h008, 2'd2, 32'h1, 0, 0, 3'd4);
    chk(r_data == 0 && r_err && req_cnt == 1, "R10 error write", r_data, 0);

    // R7 read timeout
    fast_link = 1;
    run_txn(0, 12'h010, 2'd2, 0, 0, -1, 0);
    chk(r_data == 32'hFFFFFFFF && r_crs && !r_err, "R7 timeout read data", r_data, 32'hFFFFFFFF);
    chk(r_cyc >= WIN_CYC && r_cyc <= WIN_CYC + 100, "R7 timeout timing", r_cyc, WIN_CYC);
    chk(min_gap >= GAP, "R6 spacing during window", min_gap, GAP);
    // R8 write timeout
    run_txn(1, 12'h010, 2'd2, 32'h77, 0, -1, 0);
    chk(r_err && r_crs && r_data == 0, "R8 timeout write", {r_err, r_crs}, 32'h3);
    // R7 visibility on but vendor dword read times out? no: pattern; off-dword times out
    run_txn(0, 12'h00D, 2'd0, 0, 1, -1, 0);
    chk(r_data == 32'hFF && r_crs, "R7 timeout byte read", r_data, 32'hFF);
    fast_link = 0;

    // random mix
    for (int t = 0; t < 60; t++) begin
      bit          wr, sv;
      logic [11:0] a;
      logic [1:0]  sz;
      logic [31:0] wd, base;
      int          crs, ereq;
      logic [2:0]  fst;
      wr = $urandom % 4 == 0; sv = $urandom % 2; a = 12'($urandom % 64);
      sz = 2'($urandom % 4); wd = $urandom; crs = $urandom % 4;
      fst = ($urandom % 8 == 0) ? 3'd1 : 3'd0;
      base = mem[a[5:2]];
      if (!wr && sv && a[5:2] == 0 && crs > 0) begin
        exp = shape(32'hFFFF0001, a[1:0], sz); ereq = 1;
      end else begin
        ereq = crs + 1;
        if (wr) exp = 0;
        else if (fst != 0) exp = shape(32'hFFFFFFFF, a[1:0], sz);
        else exp = shape(base, a[1:0], sz);
      end
      run_txn(wr, a, sz, wd, sv, crs, fst);
      chk(r_data == exp, sv ? "R4 R5 random data" : "R3 R9 random data", r_data, exp);
      chk(req_cnt == ereq, "R3 R5 random request count", req_cnt, ereq);
      chk(r_err == (fst != 0 && ereq != 1 || fst != 0 && !(sv && !wr && a[5:2] == 0 && crs > 0)) && !r_crs,
          "R10 R12 random flags", {r_err, r_crs}, {31'd0, fst != 0});
      if (crs > 0 && ereq > 1) chk(min_gap >= GAP, "R6 random spacing", min_gap, GAP);
      if (wr && fst == 0) chk(mem[a[5:2]] == wd, "R12 random write stored", mem[a[5:2]], wd);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule